// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block caches virtual-page to physical-page translations. It is organised as a set-associative array. The low bits of the virtual page number select a set. The remaining high bits are the tag that is compared in every way of that set.

A lookup is presented with a virtual page number and an access kind: read, write or instruction fetch. In the same cycle the block returns hit or miss, the physical page number, the dirty state of the matching entry, and a fault flag. The fault flag is raised when the stored rights forbid the access. When a lookup misses, the page-table walker sends the translation back through the refill port, and the block stores it in a way chosen by a replacement rule.

Each entry carries four status items: valid, dirty, referenced, and a two-bit rights field. Permitted hits set the referenced bit, and permitted writes also set the dirty bit. A clear command drops every referenced bit. A flush command invalidates the whole array when the active address space changes.

Top module: `tlb_xlate`

## Requirements
- R1: After reset is released, every lookup misses until a refill has been written.
- R2: The set index is the low $clog2(SETS) bits of the page number and the tag is the remaining high bits. A hit needs a valid entry with an equal tag in the indexed set, so two pages with the same index and different tags occupy separate ways and both hit.
- R3: Lookup results are combinational from the lookup inputs. lk_hit and lk_miss are both 0 while lk_valid is 0. lk_miss equals lk_valid and no match, and lk_ppn is the stored page number on a hit and 0 otherwise.
- R4: A refill takes effect at the next rising edge, so a lookup in the same cycle still misses. The new entry is valid, clean (dirty 0) and unreferenced (reference 0).
- R5: The refill way in the indexed set is the lowest-numbered invalid way. If every way is valid, it is the lowest way whose reference bit is 0. If every reference bit is also 1, it is way 0.
- R6: A refill whose page number already hits in its set overwrites that same way, so a page is never held twice.
- R7: The rights codes are 00 read-only, 01 read/write, 10 read/execute and 11 no access. The access kind codes are 00 read, 01 write and 10 fetch. Reads need any code except 11, writes need 01 and fetches need 10. lk_fault is 1 exactly on a hit whose rights forbid the access.
- R8: A hit that does not fault sets the entry's reference bit at the next edge.
- R9: A write hit that does not fault sets the entry's dirty bit at the next edge. lk_dirty reports the bit as it stood before the access, and reads never set it.
- R10: ref_clear drops every reference bit at the next edge. A permitted hit in the same cycle leaves its own entry referenced.
- R11: flush_all invalidates every entry at the next edge and takes priority over a refill in the same cycle. That refill is discarded.
- R12: A faulting lookup changes neither the reference bit nor the dirty bit of its entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Lookup present but no translation held |
| lk_ppn | output | PPN_W | Physical page number on a hit, else 0 |
| lk_fault | output | 1 | Hit whose rights forbid the access kind |
| lk_dirty | output | 1 | Dirty bit of the hit entry before this access |
| fill_valid | input | 1 | Refill from the page-table walker |
| fill_vpn | input | VPN_W | Page number being refilled |
| fill_ppn | input | PPN_W | Physical page number to store |
| fill_rights | input | 2 | Rights code to store |
| flush_all | input | 1 | Invalidate every entry |
| ref_clear | input | 1 | Clear every reference bit |

## Verification
Hit, miss, page number, dirty and fault are combinational. The bench drives each lookup just after a falling edge and samples 1 ns later, in the same cycle. Refills, flushes, reference clears, and the reference and dirty updates caused by a lookup all land at the following rising edge. Their effects are therefore checked with a lookup in a later cycle, never in the cycle of the stimulus.

The reference bits have no port of their own. The bench observes them through which way a later refill evicts, and it counts the reference bits that its own checking lookups set. Reset release passes through a two-stage synchroniser, so the bench waits several cycles before its first lookup.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Access kinds presented with a lookup
  localparam logic [1:0] KIND_READ  = 2'b00;
  localparam logic [1:0] KIND_WRITE = 2'b01;
  localparam logic [1:0] KIND_FETCH = 2'b10;

  // Rights codes stored per entry
  localparam logic [1:0] RIGHTS_RO   = 2'b00;
  localparam logic [1:0] RIGHTS_RW   = 2'b01;
  localparam logic [1:0] RIGHTS_RX   = 2'b10;
  localparam logic [1:0] RIGHTS_NONE = 2'b11;

  // Whether a stored rights code permits an access kind
  function automatic logic rights_permit(logic [1:0] rights, logic [1:0] kind);
    logic ok;
    case (kind)
      KIND_READ:  ok = (rights != RIGHTS_NONE);
      KIND_WRITE: ok = (rights == RIGHTS_RW);
      KIND_FETCH: ok = (rights == RIGHTS_RX);
      default:    ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/tlb_rst_sync.sv
module tlb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 18
) (
  input  logic [WAYS-1:0]  vld_i,
  input  logic [TAG_W-1:0] tag_i [WAYS],
  input  logic [TAG_W-1:0] key_i,
  output logic [WAYS-1:0]  hit_vec_o,
  output logic             any_o
);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec_o[w] = vld_i[w] && (tag_i[w] == key_i);
  end

  assign any_o = |hit_vec_o;

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]  vld_i,
  input  logic [WAYS-1:0]  ref_i,
  input  logic [WAYS-1:0]  hit_i,
  output logic [WAY_W-1:0] way_o
);

  // Later passes override earlier ones: existing match, then free way,
  // then unreferenced way, then way 0. Descending loops keep the lowest index.
  always_comb begin
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!ref_i[w]) way_o = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_i[w]) way_o = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_i[w]) way_o = WAY_W'(w);
    end
  end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VPN_W = 26,
  parameter int PPN_W = 22,
  parameter int SETS  = 256,
  parameter int WAYS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [1:0]       lk_kind,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_fault,
  output logic             lk_dirty,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [1:0]       fill_rights,
  input  logic             flush_all,
  input  logic             ref_clear
);

  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic rst_s_n;

  tlb_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  // Address split
  logic [IDX_W-1:0] lk_idx, fill_idx;
  logic [TAG_W-1:0] lk_tag, fill_tag;

  assign lk_idx   = lk_vpn[IDX_W-1:0];
  assign lk_tag   = lk_vpn[VPN_W-1:IDX_W];
  assign fill_idx = fill_vpn[IDX_W-1:0];
  assign fill_tag = fill_vpn[VPN_W-1:IDX_W];

  // Status bits (reset) and payload (no reset)
  logic [SETS-1:0]  vld_q [WAYS];
  logic [SETS-1:0]  vld_d [WAYS];
  logic [SETS-1:0]  ref_q [WAYS];
  logic [SETS-1:0]  ref_d [WAYS];
  logic [SETS-1:0]  dty_q [WAYS];
  logic [SETS-1:0]  dty_d [WAYS];
  logic [TAG_W-1:0] tag_mem    [WAYS][SETS];
  logic [PPN_W-1:0] ppn_mem    [WAYS][SETS];
  logic [1:0]       rights_mem [WAYS][SETS];

  // Per-way reads for the lookup set and the refill set
  logic [WAYS-1:0]  lk_vld_rd, fl_vld_rd, fl_ref_rd, lk_dty_rd;
  logic [TAG_W-1:0] lk_tag_rd [WAYS];
  logic [TAG_W-1:0] fl_tag_rd [WAYS];
  logic [PPN_W-1:0] lk_ppn_rd [WAYS];
  logic [1:0]       lk_rgt_rd [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign lk_vld_rd[w] = vld_q[w][lk_idx];
    assign lk_dty_rd[w] = dty_q[w][lk_idx];
    assign lk_tag_rd[w] = tag_mem[w][lk_idx];
    assign lk_ppn_rd[w] = ppn_mem[w][lk_idx];
    assign lk_rgt_rd[w] = rights_mem[w][lk_idx];
    assign fl_vld_rd[w] = vld_q[w][fill_idx];
    assign fl_ref_rd[w] = ref_q[w][fill_idx];
    assign fl_tag_rd[w] = tag_mem[w][fill_idx];
  end

  // Tag compare: lookup side and refill side
  logic [WAYS-1:0] lk_hit_vec, fl_hit_vec;
  logic            lk_any, fl_any;

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .vld_i     (lk_vld_rd),
    .tag_i     (lk_tag_rd),
    .key_i     (lk_tag),
    .hit_vec_o (lk_hit_vec),
    .any_o     (lk_any)
  );

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_match (
    .vld_i     (fl_vld_rd),
    .tag_i     (fl_tag_rd),
    .key_i     (fill_tag),
    .hit_vec_o (fl_hit_vec),
    .any_o     (fl_any)
  );

  // Refill way selection
  logic [WAY_W-1:0] fill_way;

  tlb_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .vld_i (fl_vld_rd),
    .ref_i (fl_ref_rd),
    .hit_i (fl_hit_vec),
    .way_o (fill_way)
  );

  // One-hot select of the matching way
  logic [PPN_W-1:0] sel_ppn;
  logic [1:0]       sel_rights;
  logic             sel_dirty;

  always_comb begin
    sel_ppn    = '0;
    sel_rights = '0;
    sel_dirty  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      sel_ppn    = sel_ppn    | (lk_ppn_rd[w] & {PPN_W{lk_hit_vec[w]}});
      sel_rights = sel_rights | (lk_rgt_rd[w] & {2{lk_hit_vec[w]}});
      sel_dirty  = sel_dirty  | (lk_dty_rd[w] & lk_hit_vec[w]);
    end
  end

  logic permit;
  assign permit   = rights_permit(sel_rights, lk_kind);
  assign lk_hit   = lk_valid & lk_any;
  assign lk_miss  = lk_valid & ~lk_any;
  assign lk_ppn   = lk_hit ? sel_ppn : '0;
  assign lk_fault = lk_hit & ~permit;
  assign lk_dirty = lk_hit & sel_dirty;

  // Update enables
  logic acc_en, wr_en, fill_en;
  assign acc_en  = lk_hit & permit;
  assign wr_en   = acc_en & (lk_kind == KIND_WRITE);
  assign fill_en = fill_valid & ~flush_all;

  // Next state: clear, then access, then refill, then flush (highest)
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      vld_d[w] = vld_q[w];
      ref_d[w] = ref_q[w];
      dty_d[w] = dty_q[w];
      if (ref_clear) ref_d[w] = '0;
      if (acc_en && lk_hit_vec[w]) begin
        ref_d[w][lk_idx] = 1'b1;
        if (wr_en) dty_d[w][lk_idx] = 1'b1;
      end
      if (fill_en && (fill_way == WAY_W'(w))) begin
        vld_d[w][fill_idx] = 1'b1;
        ref_d[w][fill_idx] = 1'b0;
        dty_d[w][fill_idx] = 1'b0;
      end
      if (flush_all) begin
        vld_d[w] = '0;
        ref_d[w] = '0;
        dty_d[w] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      for (int w = 0; w < WAYS; w++) begin
        vld_q[w] <= '0;
        ref_q[w] <= '0;
        dty_q[w] <= '0;
      end
    end else begin
      for (int w = 0; w < WAYS; w++) begin
        vld_q[w] <= vld_d[w];
        ref_q[w] <= ref_d[w];
        dty_q[w] <= dty_d[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < WAYS; w++) begin
      if (fill_en && (fill_way == WAY_W'(w))) begin
        tag_mem[w][fill_idx]    <= fill_tag;
        ppn_mem[w][fill_idx]    <= fill_ppn;
        rights_mem[w][fill_idx] <= fill_rights;
      end
    end
  end

  // Assertions
  p_hit_miss_excl_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(lk_hit && lk_miss) && (lk_miss -> lk_valid));

  p_fault_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    lk_fault |-> lk_hit);

  p_single_copy_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(lk_hit_vec));

  p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    flush_all |=> !lk_hit);

  p_fill_lands_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    fill_en |=> vld_q[$past(fill_way)][$past(fill_idx)]);

  p_free_way_first_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fill_en && !fl_any && !(&fl_vld_rd)) |-> !fl_vld_rd[fill_way]);

endmodule

// File: tb/tlb_xlate_tb.sv
`timescale 1ns/1ps
module tlb_xlate_tb;

  localparam int VPN_W = 26;
  localparam int PPN_W = 22;
  localparam logic [1:0] K_RD = 2'b00, K_WR = 2'b01, K_EX = 2'b10;
  localparam logic [1:0] A_RO = 2'b00, A_RW = 2'b01, A_RX = 2'b10, A_NO = 2'b11;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             lk_valid;
  logic [VPN_W-1:0] lk_vpn;
  logic [1:0]       lk_kind;
  logic             lk_hit, lk_miss, lk_fault, lk_dirty;
  logic [PPN_W-1:0] lk_ppn;
  logic             fill_valid;
  logic [VPN_W-1:0] fill_vpn;
  logic [PPN_W-1:0] fill_ppn;
  logic [1:0]       fill_rights;
  logic             flush_all, ref_clear;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tlb_xlate u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_kind(lk_kind),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_ppn(lk_ppn),
    .lk_fault(lk_fault), .lk_dirty(lk_dirty),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_rights(fill_rights), .flush_all(flush_all), .ref_clear(ref_clear)
  );

  function automatic logic [VPN_W-1:0] mk(int tag, int idx);
    return {18'(tag), 8'(idx)};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 0; lk_vpn = '0; lk_kind = K_RD;
    fill_valid = 0; fill_vpn = '0; fill_ppn = '0; fill_rights = A_RO;
    flush_all = 0; ref_clear = 0;
  endtask

  // Lookup: drive after falling edge, check in-cycle, release after rising edge
  task automatic look(string req, logic [VPN_W-1:0] v, logic [1:0] k, bit eh,
                      logic [PPN_W-1:0] ep, bit ef, bit ed, bit clr = 0);
    @(negedge clk);
    lk_valid = 1; lk_vpn = v; lk_kind = k; ref_clear = clr;
    #1;
    chk(req, "hit", 32'(lk_hit), 32'(eh));
    chk(req, "miss", 32'(lk_miss), 32'(!eh));
    if (eh) begin
      chk(req, "ppn", 32'(lk_ppn), 32'(ep));
      chk(req, "fault", 32'(lk_fault), 32'(ef));
      chk(req, "dirty", 32'(lk_dirty), 32'(ed));
    end
    @(posedge clk); #1 idle();
  endtask

  task automatic fill(logic [VPN_W-1:0] v, logic [PPN_W-1:0] p, logic [1:0] r, bit fl = 0);
    @(negedge clk);
    fill_valid = 1; fill_vpn = v; fill_ppn = p; fill_rights = r; flush_all = fl;
    @(posedge clk); #1 idle();
  endtask

  task automatic pulse_clear();
    @(negedge clk); ref_clear = 1;
    @(posedge clk); #1 idle();
  endtask

  task automatic t_reset();
    look("R1", mk(1, 5), K_RD, 0, 0, 0, 0);
    look("R1", mk(0, 0), K_RD, 0, 0, 0, 0);
  endtask

  task automatic t_basic();
    // R4: lookup in the refill cycle still misses
    @(negedge clk);
    fill_valid = 1; fill_vpn = mk(1, 5); fill_ppn = 22'h12345; fill_rights = A_RW;
    lk_valid = 1; lk_vpn = mk(1, 5); lk_kind = K_RD;
    #1 chk("R4", "same-cycle miss", 32'(lk_miss), 32'd1);
    @(posedge clk); #1 idle();
    look("R4", mk(1, 5), K_RD, 1, 22'h12345, 0, 0);
    // R3: no request, no result
    @(negedge clk); lk_vpn = mk(1, 5); lk_valid = 0;
    #1 chk("R3", "idle hit", 32'(lk_hit), 32'd0);
    chk("R3", "idle miss", 32'(lk_miss), 32'd0);
    @(posedge clk); #1 idle();
    // R2: same index other tag misses, then both coexist
    look("R2", mk(2, 5), K_RD, 0, 0, 0, 0);
    fill(mk(2, 5), 22'h0abcd, A_RW);
    look("R2", mk(2, 5), K_RD, 1, 22'h0abcd, 0, 0);
    look("R2", mk(1, 5), K_RD, 1, 22'h12345, 0, 0);
  endtask

  task automatic t_dirty();
    look("R9", mk(1, 5), K_WR, 1, 22'h12345, 0, 0);
    look("R9", mk(1, 5), K_RD, 1, 22'h12345, 0, 1);
    look("R9", mk(2, 5), K_RD, 1, 22'h0abcd, 0, 0);
    look("R9", mk(2, 5), K_RD, 1, 22'h0abcd, 0, 0);
  endtask

  task automatic t_rights();
    fill(mk(3, 40), 22'h00040, A_RO);
    look("R7", mk(3, 40), K_RD, 1, 22'h00040, 0, 0);
    look("R7", mk(3, 40), K_WR, 1, 22'h00040, 1, 0);
    look("R12", mk(3, 40), K_RD, 1, 22'h00040, 0, 0);
    look("R7", mk(3, 40), K_EX, 1, 22'h00040, 1, 0);
    fill(mk(3, 41), 22'h00041, A_RX);
    look("R7", mk(3, 41), K_EX, 1, 22'h00041, 0, 0);
    look("R7", mk(3, 41), K_RD, 1, 22'h00041, 0, 0);
    look("R7", mk(3, 41), K_WR, 1, 22'h00041, 1, 0);
    fill(mk(3, 42), 22'h00042, A_NO);
    look("R7", mk(3, 42), K_RD, 1, 22'h00042, 1, 0);
    look("R7", mk(3, 5), K_EX, 0, 0, 0, 0);
  endtask

  task automatic t_replace();
    fill(mk(11, 9), 22'h00011, A_RW);
    fill(mk(12, 9), 22'h00012, A_RW);
    fill(mk(13, 9), 22'h00013, A_RW);
    look("R5", mk(11, 9), K_RD, 0, 0, 0, 0);
    look("R5", mk(12, 9), K_RD, 1, 22'h00012, 0, 0);
    look("R5", mk(13, 9), K_RD, 1, 22'h00013, 0, 0);
    fill(mk(14, 9), 22'h00014, A_RW);
    look("R8", mk(13, 9), K_RD, 0, 0, 0, 0);
    look("R8", mk(12, 9), K_RD, 1, 22'h00012, 0, 0);
    look("R8", mk(14, 9), K_RD, 1, 22'h00014, 0, 0);
    pulse_clear();
    look("R10", mk(14, 9), K_RD, 1, 22'h00014, 0, 0);
    fill(mk(15, 9), 22'h00015, A_RW);
    look("R10", mk(12, 9), K_RD, 0, 0, 0, 0);
    look("R10", mk(14, 9), K_RD, 1, 22'h00014, 0, 0);
    look("R10", mk(15, 9), K_RD, 1, 22'h00015, 0, 0);
    look("R10", mk(15, 9), K_RD, 1, 22'h00015, 0, 0, 1);
    fill(mk(16, 9), 22'h00016, A_RW);
    look("R10", mk(14, 9), K_RD, 0, 0, 0, 0);
    look("R10", mk(15, 9), K_RD, 1, 22'h00015, 0, 0);
    look("R10", mk(16, 9), K_RD, 1, 22'h00016, 0, 0);
  endtask

  task automatic t_fault_quiet();
    fill(mk(21, 11), 22'h00021, A_RO);
    fill(mk(22, 11), 22'h00022, A_RO);
    look("R12", mk(22, 11), K_WR, 1, 22'h00022, 1, 0);
    look("R12", mk(21, 11), K_RD, 1, 22'h00021, 0, 0);
    fill(mk(23, 11), 22'h00023, A_RO);
    look("R12", mk(22, 11), K_RD, 0, 0, 0, 0);
    look("R12", mk(21, 11), K_RD, 1, 22'h00021, 0, 0);
    look("R12", mk(23, 11), K_RD, 1, 22'h00023, 0, 0);
  endtask

  task automatic t_refill_same();
    fill(mk(31, 13), 22'h00111, A_RW);
    fill(mk(31, 13), 22'h00222, A_RW);
    look("R6", mk(31, 13), K_RD, 1, 22'h00222, 0, 0);
    fill(mk(32, 13), 22'h00333, A_RW);
    look("R6", mk(31, 13), K_RD, 1, 22'h00222, 0, 0);
    look("R6", mk(32, 13), K_RD, 1, 22'h00333, 0, 0);
  endtask

  task automatic t_flush();
    fill(mk(41, 30), 22'h00444, A_RW, 1);
    look("R11", mk(41, 30), K_RD, 0, 0, 0, 0);
    look("R11", mk(1, 5), K_RD, 0, 0, 0, 0);
    look("R11", mk(31, 13), K_RD, 0, 0, 0, 0);
    fill(mk(1, 5), 22'h00555, A_RW);
    look("R11", mk(1, 5), K_RD, 1, 22'h00555, 0, 0);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);
    t_reset();
    t_basic();
    t_dirty();
    t_rights();
    t_replace();
    t_fault_quiet();
    t_refill_same();
    t_flush();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule